// File: doc/BRIEF.md
# Cascaded Biquad IIR Filter Engine with One Shared Multiply-Accumulator

This block filters a stream of signed samples through a chain of second-order IIR sections in direct form I. Every product of every section runs through one signed multiply-accumulate unit, in a fixed schedule. The gain product, the three feed-forward taps and the two feedback taps of each section use that unit in turn. The coefficients and the per-section gain constants are elaboration-time parameters in two's-complement fixed point.

A sample is offered with a one-cycle valid strobe while the engine is idle. It then passes through section 0, section 1 and so on, with seven cycles of multiplier use per section. The filtered value comes out with a one-cycle valid pulse. Each section keeps its own two past inputs and two past outputs. The engine suits sample rates well below the clock rate, where a single multiplier can serve the whole cascade.

Top module: `iir_cascade_engine`

## Requirements
- R1: When reset is asserted, `out_valid` and `out_data` are 0 and every section's history is zero. The first output after reset depends only on the samples that follow the reset.
- R2: Each section first multiplies its input by its gain constant, which has GAIN_FRAC (default 18) fractional bits. It rounds the product half-up to DW bits, saturating at the DW-bit limits. The rounded value is the section's newest input-history entry g[n].
- R3: The feed-forward part adds b1*g[n] + b2*g[n-1] + b3*g[n-2]. The taps have COEF_FRAC (default 16) fractional bits.
- R4: The feedback part subtracts a2*y[n-1] + a3*y[n-2] from the same accumulator.
- R5: The accumulated sum is rounded half-up over COEF_FRAC bits and saturated to the range [-2^(DW-1), 2^(DW-1)-1]. The result is stored as y[n] and becomes the next section's input.
- R6: A section takes exactly 7 cycles. If the strobe is sampled at clock edge k, `out_valid` rises after edge k + 7*NSEC.
- R7: A strobe that arrives while a computation is in progress is ignored, including one in the last cycle of that computation. Neither the output value nor the filter history changes because of it.
- R8: `out_valid` is a single-cycle pulse.
- R9: `out_data` keeps its last value between pulses.
- R10: A strobe presented in the same cycle as `out_valid` is accepted. Samples can therefore follow each other every 7*NSEC+1 cycles.
- R11: A reset asserted in the middle of a computation drops that computation and clears all histories.
- R12: Section i's gain is at bits [i*CW +: CW] of GAIN. Feed-forward tap k (k=0 for b1, 1 for b2, 2 for b3) is at [(3i+k)*CW +: CW] of BNUM. Feedback tap k (k=0 for a2, 1 for a3) is at [(2i+k)*CW +: CW] of ADEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, accepted only while idle |
| in_data | input | DW (20) | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | DW (20) | Signed filtered sample, held between pulses |

## Verification
Two events can fall in the same cycle: the last section delivering its result with the `out_valid` pulse, and a new sample being accepted. The bench provokes this by sending samples back to back, each strobe placed exactly in the cycle where the previous pulse is expected. It judges the result two ways. Every result must match an integer model of the rounding and saturation rules, and every pulse must arrive exactly 7*NSEC cycles after its own accepting edge. A strobe placed one cycle earlier, during the final step, must leave both the value stream and the timing untouched.

// File: rtl/iir_eng_pkg.sv
package iir_eng_pkg;

  // multiply-accumulate operation selected by the sequencer
  typedef enum logic [1:0] {
    MAC_HOLD = 2'd0,
    MAC_LOAD = 2'd1,
    MAC_ADD  = 2'd2,
    MAC_SUB  = 2'd3
  } mac_op_e;

  // per-section schedule; order fixes which operand meets the multiplier
  localparam logic [2:0] ST_GAIN = 3'd0;
  localparam logic [2:0] ST_B1   = 3'd1;
  localparam logic [2:0] ST_B2   = 3'd2;
  localparam logic [2:0] ST_B3   = 3'd3;
  localparam logic [2:0] ST_A2   = 3'd4;
  localparam logic [2:0] ST_A3   = 3'd5;
  localparam logic [2:0] ST_OUT  = 3'd6;

endpackage

// File: rtl/iir_rst_sync.sv
module iir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/iir_round.sv
// Round-half-up over FRAC discarded bits, then clamp to OUTW signed bits.
module iir_round #(
  parameter int INW  = 41,
  parameter int FRAC = 16,
  parameter int OUTW = 20
) (
  input  logic signed [INW-1:0]  din,
  output logic signed [OUTW-1:0] dout
);
  localparam int SW = INW + 1;

  localparam logic signed [SW-1:0] HALF =
    {{(SW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [SW-1:0] HI_LIM =
    {{(SW-OUTW+1){1'b0}}, {(OUTW-1){1'b1}}};
  localparam logic signed [SW-1:0] LO_LIM =
    {{(SW-OUTW+1){1'b1}}, {(OUTW-1){1'b0}}};

  logic signed [SW-1:0] biased;
  logic signed [SW-1:0] shifted;

  always_comb begin
    biased  = $signed({din[INW-1], din}) + HALF;
    shifted = biased >>> FRAC;
    if (shifted > HI_LIM)
      dout = HI_LIM[OUTW-1:0];
    else if (shifted < LO_LIM)
      dout = LO_LIM[OUTW-1:0];
    else
      dout = shifted[OUTW-1:0];
  end
endmodule

// File: rtl/iir_mac.sv
module iir_mac
  import iir_eng_pkg::*;
#(
  parameter int AW   = 20,
  parameter int BW   = 18,
  parameter int ACCW = 41
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  mac_op_e                op,
  input  logic signed [AW-1:0]   opa,
  input  logic signed [BW-1:0]   opb,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW = AW + BW;

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_x;
  logic signed [ACCW-1:0] acc_d;
  logic signed [ACCW-1:0] acc_q;
  logic                   acc_en;

  always_comb begin
    prod   = opa * opb;
    prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};
    acc_en = (op != MAC_HOLD);
    unique case (op)
      MAC_LOAD: acc_d = prod_x;
      MAC_ADD:  acc_d = acc_q + prod_x;
      MAC_SUB:  acc_d = acc_q - prod_x;
      default:  acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/iir_sec_state.sv
// Two-deep input and output history of one section.
module iir_sec_state #(
  parameter int DW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic signed [DW-1:0] x_new,
  input  logic signed [DW-1:0] y_new,
  output logic signed [DW-1:0] x1,
  output logic signed [DW-1:0] x2,
  output logic signed [DW-1:0] y1,
  output logic signed [DW-1:0] y2
);
  logic signed [DW-1:0] x1_q, x2_q, y1_q, y2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end else if (we) begin
      x2_q <= x1_q;
      x1_q <= x_new;
      y2_q <= y1_q;
      y1_q <= y_new;
    end
  end

  assign x1 = x1_q;
  assign x2 = x2_q;
  assign y1 = y1_q;
  assign y2 = y2_q;
endmodule

// File: rtl/iir_seq.sv
module iir_seq
  import iir_eng_pkg::*;
#(
  parameter int NSEC = 2,
  parameter int SECW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            busy,
  output logic [2:0]      step,
  output logic [SECW-1:0] sec,
  output logic            accept,
  output logic            sec_done,
  output logic            last_done,
  output mac_op_e         op
);
  localparam logic [SECW-1:0] LAST_SEC = SECW'(NSEC - 1);

  logic            busy_q, busy_d;
  logic [2:0]      step_q, step_d;
  logic [SECW-1:0] sec_q, sec_d;

  always_comb begin
    accept    = in_valid && !busy_q;
    sec_done  = busy_q && (step_q == ST_OUT);
    last_done = sec_done && (sec_q == LAST_SEC);

    busy_d = busy_q;
    step_d = step_q;
    sec_d  = sec_q;
    if (accept) begin
      busy_d = 1'b1;
      step_d = ST_GAIN;
      sec_d  = '0;
    end else if (busy_q) begin
      if (step_q == ST_OUT) begin
        step_d = ST_GAIN;
        if (sec_q == LAST_SEC) busy_d = 1'b0;
        else                   sec_d  = sec_q + 1'b1;
      end else begin
        step_d = step_q + 3'd1;
      end
    end

    op = MAC_HOLD;
    if (busy_q) begin
      case (step_q)
        ST_GAIN, ST_B1: op = MAC_LOAD;
        ST_B2, ST_B3:   op = MAC_ADD;
        ST_A2, ST_A3:   op = MAC_SUB;
        default:        op = MAC_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= ST_GAIN;
      sec_q  <= '0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      sec_q  <= sec_d;
    end
  end

  assign busy = busy_q;
  assign step = step_q;
  assign sec  = sec_q;

  // R6: inside a section the schedule moves one step per cycle
  assert_step_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step_q != ST_OUT) |=> (step_q == $past(step_q) + 3'd1));

  // R6: every computation starts at the first step of section 0
  assert_start_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (step_q == ST_GAIN && sec_q == '0));

  // R7: a strobe during a computation neither restarts nor reorders it
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_valid && step_q != ST_OUT) |=> (busy_q && sec_q == $past(sec_q)));
endmodule

// File: rtl/iir_cascade_engine.sv
module iir_cascade_engine
  import iir_eng_pkg::*;
#(
  parameter int DW        = 20,
  parameter int CW        = 18,
  parameter int NSEC      = 2,
  parameter int GAIN_FRAC = 18,
  parameter int COEF_FRAC = 16,
  parameter logic [NSEC*CW-1:0]   GAIN = {18'h1FFFF, 18'h10000},
  parameter logic [NSEC*3*CW-1:0] BNUM = {18'h00000, 18'h00000, 18'h10000,
                                          18'h04000, 18'h08000, 18'h04000},
  parameter logic [NSEC*2*CW-1:0] ADEN = {18'h00000, 18'h33333,
                                          18'h04000, 18'h30000}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int SECW = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int ACCW = DW + CW + 3;

  logic            rst_s;
  logic            busy, accept, sec_done, last_done;
  logic [2:0]      step;
  logic [SECW-1:0] sec;
  mac_op_e         op;

  logic signed [CW-1:0]   gain_a [NSEC];
  logic signed [CW-1:0]   b1_a [NSEC], b2_a [NSEC], b3_a [NSEC];
  logic signed [CW-1:0]   a2_a [NSEC], a3_a [NSEC];
  logic signed [DW-1:0]   x1_a [NSEC], x2_a [NSEC], y1_a [NSEC], y2_a [NSEC];

  logic signed [ACCW-1:0] acc;
  logic signed [DW-1:0]   g_rnd, y_rnd;
  logic signed [DW-1:0]   opa;
  logic signed [CW-1:0]   opb;

  logic signed [DW-1:0]   x_cur_q, x_cur_d;
  logic                   x_cur_en;
  logic signed [DW-1:0]   g_q;
  logic                   g_en;
  logic [DW-1:0]          out_q;
  logic                   out_en;
  logic                   ov_q;

  iir_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  iir_seq #(.NSEC(NSEC), .SECW(SECW)) u_seq (
    .clk(clk), .rst_n(rst_s), .in_valid(in_valid),
    .busy(busy), .step(step), .sec(sec), .accept(accept),
    .sec_done(sec_done), .last_done(last_done), .op(op)
  );

  generate
    for (genvar i = 0; i < NSEC; i++) begin : g_sec
      assign gain_a[i] = GAIN[i*CW +: CW];
      assign b1_a[i]   = BNUM[(3*i+0)*CW +: CW];
      assign b2_a[i]   = BNUM[(3*i+1)*CW +: CW];
      assign b3_a[i]   = BNUM[(3*i+2)*CW +: CW];
      assign a2_a[i]   = ADEN[(2*i+0)*CW +: CW];
      assign a3_a[i]   = ADEN[(2*i+1)*CW +: CW];

      iir_sec_state #(.DW(DW)) u_hist (
        .clk(clk), .rst_n(rst_s),
        .we(sec_done && (sec == SECW'(i))),
        .x_new(g_q), .y_new(y_rnd),
        .x1(x1_a[i]), .x2(x2_a[i]), .y1(y1_a[i]), .y2(y2_a[i])
      );
    end
  endgenerate

  // operand selection follows the step schedule
  always_comb begin
    opa = '0;
    opb = '0;
    case (step)
      ST_GAIN: begin opa = x_cur_q;   opb = gain_a[sec]; end
      ST_B1:   begin opa = g_rnd;     opb = b1_a[sec];   end
      ST_B2:   begin opa = x1_a[sec]; opb = b2_a[sec];   end
      ST_B3:   begin opa = x2_a[sec]; opb = b3_a[sec];   end
      ST_A2:   begin opa = y1_a[sec]; opb = a2_a[sec];   end
      ST_A3:   begin opa = y2_a[sec]; opb = a3_a[sec];   end
      default: begin opa = '0;        opb = '0;          end
    endcase
  end

  iir_mac #(.AW(DW), .BW(CW), .ACCW(ACCW)) u_mac (
    .clk(clk), .rst_n(rst_s), .op(op), .opa(opa), .opb(opb), .acc(acc)
  );

  iir_round #(.INW(ACCW), .FRAC(GAIN_FRAC), .OUTW(DW)) u_rnd_gain (
    .din(acc), .dout(g_rnd)
  );

  iir_round #(.INW(ACCW), .FRAC(COEF_FRAC), .OUTW(DW)) u_rnd_sec (
    .din(acc), .dout(y_rnd)
  );

  // next-state logic for the data registers
  always_comb begin
    x_cur_en = accept || sec_done;
    x_cur_d  = accept ? $signed(in_data) : y_rnd;
    g_en     = busy && (step == ST_B1);
    out_en   = last_done;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      x_cur_q <= '0;
      g_q     <= '0;
      out_q   <= '0;
      ov_q    <= 1'b0;
    end else begin
      if (x_cur_en) x_cur_q <= x_cur_d;
      if (g_en)     g_q     <= g_rnd;
      if (out_en)   out_q   <= y_rnd;
      ov_q <= last_done;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = out_q;

  // R8: the result strobe never lasts two cycles
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |=> !out_valid);

  // R9: the result is held whenever no pulse is present
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !out_valid |-> $stable(out_data));

  // R5: a section result only leaves through the output after the last section
  assert_out_after_last_R5: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> (!busy || (step == ST_GAIN && sec == '0)));
endmodule

// File: tb/iir_cascade_engine_test.sv
`timescale 1ns/1ps
module iir_cascade_engine_test;
  localparam int DW  = 20;
  localparam int LAT = 14;   // 7 cycles times 2 sections

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  iir_cascade_engine #(
    .DW(20), .CW(18), .NSEC(2), .GAIN_FRAC(18), .COEF_FRAC(16),
    .GAIN({18'h1FFFF, 18'h10000}),
    .BNUM({18'h00000, 18'h00000, 18'h10000, 18'h04000, 18'h08000, 18'h04000}),
    .ADEN({18'h00000, 18'h33333, 18'h04000, 18'h30000})
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // reference coefficients (R12 layout), integer form
  longint G [2]    = '{65536, 131071};
  longint B [2][3] = '{'{16384, 32768, 16384}, '{65536, 0, 0}};
  longint A [2][2] = '{'{-65536, 16384}, '{-52429, 0}};
  longint mx1 [2], mx2 [2], my1 [2], my2 [2];

  typedef struct { longint val; longint due; string tag; } item_t;
  item_t  sb [$];
  longint cyc = 0;
  int     checks = 0, errors = 0;
  longint last_val = 0;
  bit     prev_ov = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint rs(longint v, int f);
    longint r;
    r = (v + (longint'(1) <<< (f - 1))) >>> f;
    if (r > 524287)       r = 524287;
    else if (r < -524288) r = -524288;
    return r;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) begin
      mx1[i] = 0; mx2[i] = 0; my1[i] = 0; my2[i] = 0;
    end
  endfunction

  function automatic longint model_step(longint x);
    longint g, acc, y, v;
    v = x;
    for (int s = 0; s < 2; s++) begin
      g   = rs(v * G[s], 18);
      acc = B[s][0]*g + B[s][1]*mx1[s] + B[s][2]*mx2[s]
          - A[s][0]*my1[s] - A[s][1]*my2[s];
      y   = rs(acc, 16);
      mx2[s] = mx1[s]; mx1[s] = g;
      my2[s] = my1[s]; my1[s] = y;
      v = y;
    end
    return v;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one strobe, expected item pushed to the scoreboard
  task automatic send(longint d, string tag);
    item_t it;
    in_valid = 1'b1;
    in_data  = d[DW-1:0];
    it.val = model_step(d);
    it.due = cyc + 1 + LAT;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(longint d, string tag, int extra);
    send(d, tag);
    repeat (LAT + extra) @(negedge clk);
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ov) chk(!out_valid, "R8", out_valid, 0);
      if (out_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R7", longint'($signed(out_data)), 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(longint'($signed(out_data)) == it.val, it.tag,
              longint'($signed(out_data)), it.val);
          chk(cyc == it.due, "R6", cyc, it.due);
        end
        last_val = longint'($signed(out_data));
      end
      prev_ov = out_valid;
    end else begin
      prev_ov = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R6 watchdog actual=%0d expected=0", sb.size());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_data == '0, "R1", longint'($signed(out_data)), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // impulse response: gain, feed-forward and feedback paths
    run(200000, "R1", 2);
    for (int i = 0; i < 10; i++) run(0, (i < 5) ? "R3" : "R4", 3);
    repeat (3) @(negedge clk);
    chk(longint'($signed(out_data)) == last_val, "R9",
        longint'($signed(out_data)), last_val);

    // small samples: gain rounding half-up, both signs
    run(3, "R2", 1);
    run(-3, "R2", 1);
    run(1, "R2", 1);
    run(-2, "R2", 1);
    for (int i = 0; i < 4; i++) run(0, "R2", 1);

    // step response, back to back: accept in the pulse cycle
    for (int i = 0; i < 12; i++) run(100000, "R10", 0);

    // saturation at both limits
    for (int i = 0; i < 16; i++) run(524287, "R5", 0);
    for (int i = 0; i < 16; i++) run(-524288, "R5", 0);

    // strobes while busy, including the final step, must be ignored
    send(50000, "R7");
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_data = 20'h7FFFF;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    in_valid = 1'b1; in_data = 20'h80000;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    run(-40000, "R7", 2);
    run(0, "R7", 2);

    // reset in the middle of a computation
    send(300000, "R11");
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    sb.delete();
    model_reset();
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R11", out_valid, 0);
    chk(out_data == '0, "R11", longint'($signed(out_data)), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run(200000, "R11", 1);
    for (int i = 0; i < 5; i++) run(0, "R11", 1);

    repeat (20) @(negedge clk);
    chk(sb.size() == 0, "R6", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule